// File: doc/BRIEF.md
# Configurable UART frame transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. A producer offers a byte with a valid/ready handshake. Once the transmitter accepts the byte, it sends a start bit, then the character bits, then an optional parity bit, then one or two stop bits. After that it returns to idle and can accept the next byte.

Five run-time inputs shape the frame: the character length (7 or 8 bits), the parity mode, the stop-bit count, the bit order and the line polarity. The block captures all five in the cycle that accepts the byte. Changes to these inputs during a frame have no effect on that frame. The block has no baud-rate logic of its own. It moves the line by one bit for each one-cycle pulse on its tick input, so an external divider sets the bit rate.

Top module: `uart_frame_tx`

## Requirements
- R1: The first bit of every frame is a single start bit, 0 at normal polarity. It appears on `tx_line` in the cycle after the first `baud_tick` that follows acceptance. A tick in the accepting cycle itself is not used.
- R2: When `cfg_len7`=1 the frame carries 7 character bits, and bit 7 of `in_data` has no effect on the line. When `cfg_len7`=0 it carries 8 character bits.
- R3: When `cfg_msb_first`=0 the character is sent starting with D0. When `cfg_msb_first`=1 it is sent starting with the highest character bit: D7 for 8 bits, D6 for 7 bits.
- R4: `cfg_parity` selects the parity mode: 2'b00 sends no parity slot, 2'b01 is even, 2'b10 is odd, 2'b11 always sends 0. Even parity makes the number of ones across the configured character bits plus the parity bit even. Odd parity makes that number odd. The parity bit comes directly after the last character bit.
- R5: After the parity bit, or after the character if there is no parity, the frame sends one stop bit of value 1 when `cfg_stop2`=0 and two when `cfg_stop2`=1.
- R6: When `cfg_invert`=1 every level on `tx_line` is complemented, the idle level included. While the block is idle, `tx_line` shows the idle level for the `cfg_invert` value of the previous cycle.
- R7: During a frame, `tx_line` changes only in the cycle after a `baud_tick`. Each frame bit is held for one full tick period.
- R8: `in_ready` equals the inverse of `busy`. A byte is accepted in a cycle where `in_valid` and `in_ready` are both high. `busy` rises in the next cycle. It falls in the cycle after the first tick that comes once the last stop bit has been held for one period.
- R9: The configuration inputs are captured at acceptance. Changing them during a frame alters neither that frame nor its trailing idle level.
- R10: After reset, `busy` is 0, `in_ready` is 1 and `tx_line` is 1 when `cfg_invert`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The transmitter can accept a byte |
| in_data | input | 8 | Character to send |
| cfg_len7 | input | 1 | 1: 7-bit character, 0: 8-bit character |
| cfg_parity | input | 2 | Parity mode (00 none, 01 even, 10 odd, 11 zero) |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_msb_first | input | 1 | 1: highest character bit first |
| cfg_invert | input | 1 | 1: inverted line levels |
| tx_line | output | 1 | Serial output |
| busy | output | 1 | A frame is in progress |

## Verification
The bench builds the block with its default 8-bit maximum character width, which gives a frame of at most 12 bits. That keeps the configuration space small: all 64 combinations of length, parity, stop count, order and polarity are swept, and each one is sent four bytes, bit 7 set among them. The bench computes every frame bit arithmetically and checks it both just after its tick and just before the next tick. It also scrambles the configuration inputs in the middle of each frame, so the effect of capturing them at acceptance is visible on the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_MAX  = 8;
    localparam int STOP_MAX  = 2;
    localparam int FRAME_MAX = 1 + CHAR_MAX + 1 + STOP_MAX;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_ZERO = 2'b11
    } parity_e;

    typedef struct packed {
        logic    len7;
        parity_e parity;
        logic    stop2;
        logic    msb_first;
    } tx_cfg_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;   // bit 0 goes out first
        logic [CNT_W-1:0]     count;
    } frame_t;

    function automatic logic parity_of(input logic [CHAR_MAX-1:0] chr,
                                       input parity_e mode);
        logic x;
        x = ^chr;
        case (mode)
            PAR_EVEN: parity_of = x;
            PAR_ODD:  parity_of = ~x;
            default:  parity_of = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
(
    input  logic [CHAR_MAX-1:0] data,
    input  tx_cfg_t             cfg,
    output frame_t              frame
);
    localparam int NSHORT = CHAR_MAX - 1;

    logic [CHAR_MAX-1:0] masked;
    logic [CHAR_MAX-1:0] ordered;
    int                  nchar;
    int                  pos;

    always_comb begin
        nchar  = cfg.len7 ? NSHORT : CHAR_MAX;
        masked = data;
        if (cfg.len7)
            masked[CHAR_MAX-1] = 1'b0;
    end

    // character bits rearranged into send order for both lengths
    always_comb begin
        ordered = '0;
        for (int i = 0; i < CHAR_MAX; i++) begin
            if (i < nchar)
                ordered[i] = cfg.msb_first ? masked[nchar-1-i] : masked[i];
        end
    end

    always_comb begin
        frame.bits    = '1;
        frame.bits[0] = 1'b0;
        pos           = 1;
        for (int i = 0; i < CHAR_MAX; i++) begin
            if (i < nchar) begin
                frame.bits[pos] = ordered[i];
                pos = pos + 1;
            end
        end
        if (cfg.parity != PAR_NONE) begin
            frame.bits[pos] = parity_of(masked, cfg.parity);
            pos = pos + 1;
        end
        pos = pos + (cfg.stop2 ? STOP_MAX : 1);
        frame.count = CNT_W'(pos);
    end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   baud_tick,
    input  logic   load,
    input  frame_t frame,
    input  logic   invert_in,
    output logic   busy,
    output logic   line
);
    logic [FRAME_MAX-1:0] sh_q;
    logic [CNT_W-1:0]     rem_q;
    logic                 busy_q;
    logic                 bit_q;
    logic                 inv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            rem_q  <= '0;
            busy_q <= 1'b0;
            bit_q  <= 1'b1;
            inv_q  <= 1'b0;
        end else begin
            if (!busy_q)
                inv_q <= invert_in;
            if (load) begin
                sh_q   <= frame.bits;
                rem_q  <= frame.count;
                busy_q <= 1'b1;
            end else if (busy_q && baud_tick) begin
                if (rem_q != '0) begin
                    bit_q <= sh_q[0];
                    sh_q  <= {1'b1, sh_q[FRAME_MAX-1:1]};
                    rem_q <= rem_q - 1'b1;
                end else begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign busy = busy_q;
    assign line = bit_q ^ inv_q;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       cfg_len7,
    input  logic [1:0] cfg_parity,
    input  logic       cfg_stop2,
    input  logic       cfg_msb_first,
    input  logic       cfg_invert,
    output logic       tx_line,
    output logic       busy
);
    tx_cfg_t cfg;
    frame_t  frame;
    logic    accept;
    logic    busy_w;

    always_comb begin
        cfg.len7      = cfg_len7;
        cfg.parity    = parity_e'(cfg_parity);
        cfg.stop2     = cfg_stop2;
        cfg.msb_first = cfg_msb_first;
    end

    uart_tx_framer u_framer (
        .data  (in_data),
        .cfg   (cfg),
        .frame (frame)
    );

    assign accept = in_valid && !busy_w;

    uart_tx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .load      (accept),
        .frame     (frame),
        .invert_in (cfg_invert),
        .busy      (busy_w),
        .line      (tx_line)
    );

    assign busy     = busy_w;
    assign in_ready = !busy_w;

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic tx_line,
    input logic cfg_invert
);
    // R8: an accepted byte starts a frame in the next cycle
    a_r8_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> busy);

    // R8: no acceptance while a frame is in progress
    a_r8_no_ready_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);

    // R7: the line holds between ticks during a frame
    a_r7_line_only_on_tick: assert property (@(posedge clk) disable iff (rst)
        (busy && !baud_tick) |=> $stable(tx_line));

    // R6: idle level tracks the polarity input of the previous cycle
    a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && $past(!rst)) |-> (tx_line == !$past(cfg_invert)));

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .busy       (busy),
    .tx_line    (tx_line),
    .cfg_invert (cfg_invert)
);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;
    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       cfg_len7 = 1'b0;
    logic [1:0] cfg_parity = '0;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       tx_line;
    logic       busy;

    int total = 0;
    int bad   = 0;
    int tcnt  = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tcnt      <= (tcnt == DIV - 1) ? 0 : tcnt + 1;
        baud_tick <= (tcnt == DIV - 1);
    end

    uart_frame_tx u_dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .cfg_len7(cfg_len7), .cfg_parity(cfg_parity), .cfg_stop2(cfg_stop2),
        .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
        .tx_line(tx_line), .busy(busy)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic l7, input logic [1:0] par,
                        input logic s2, input logic msb, input logic inv);
        logic exp [0:11];
        int   n;
        int   nc;
        int   ones;
        logic held;
        nc = l7 ? 7 : 8;
        n  = 0;
        ones = 0;
        exp[n] = 1'b0; n++;
        for (int i = 0; i < nc; i++) begin
            exp[n] = msb ? d[nc-1-i] : d[i];
            ones += int'(d[i]);
            n++;
        end
        if (par != 2'b00) begin
            exp[n] = (par == 2'b01) ? ones[0] : (par == 2'b10) ? !ones[0] : 1'b0;
            n++;
        end
        exp[n] = 1'b1; n++;
        if (s2) begin exp[n] = 1'b1; n++; end

        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data = d; cfg_len7 = l7; cfg_parity = par; cfg_stop2 = s2;
        cfg_msb_first = msb; cfg_invert = inv; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        // R9: scramble configuration mid-frame
        cfg_len7 = !l7; cfg_parity = ~par; cfg_stop2 = !s2;
        cfg_msb_first = !msb; cfg_invert = !inv; in_data = ~d;
        check("R8 busy after accept", busy, 1'b1);
        check("R8 ready low while busy", in_ready, 1'b0);
        held = 1'b1 ^ inv;
        for (int k = 0; k < n; k++) begin
            while (!baud_tick) @(negedge clk);
            check("R7 bit held until tick", tx_line, held);
            @(negedge clk);
            held = exp[k] ^ inv;
            if (k == 0)
                check("R1 start bit", tx_line, held);
            else if (k <= nc)
                check(msb ? "R3 R2 char bit msb-first" : "R2 R3 char bit lsb-first",
                      tx_line, held);
            else if (par != 2'b00 && k == nc + 1)
                check("R4 parity bit", tx_line, held);
            else
                check("R5 stop bit", tx_line, held);
            check("R9 R6 polarity latched", busy, 1'b1);
        end
        while (!baud_tick) @(negedge clk);
        check("R5 last stop held", tx_line, held);
        @(negedge clk);
        check("R8 busy falls", busy, 1'b0);
        check("R8 ready returns", in_ready, 1'b1);
        check("R6 R9 trailing idle level", tx_line, 1'b1 ^ inv);
        cfg_invert = inv;
        @(negedge clk);
        check("R6 idle level", tx_line, 1'b1 ^ inv);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset busy", busy, 1'b0);
        check("R10 reset ready", in_ready, 1'b1);
        check("R10 reset line", tx_line, 1'b1);
        for (int c = 0; c < 64; c++) begin
            for (int r = 0; r < 4; r++) begin
                logic [7:0] d;
                d = (r == 0) ? 8'h80 : (r == 1) ? 8'h7F : 8'(c * 37 + r * 101 + 5);
                send(d, c[0], c[2:1], c[3], c[4], c[5]);
            end
        end
        done = 1;
    end

    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule